// File: doc/BRIEF.md
# Radio Symbol Counter with Compare Units

This block keeps the symbol time for a low-rate wireless MAC. A 32-bit counter advances once per 16 µs symbol. The symbol tick comes from an 8-bit prescaler that runs on the 16 MHz reference clock. A second counter divides symbols into 20-symbol (320 µs) backoff slots and gives a one-cycle pulse at the end of each slot. When the slow source is selected, the prescaler stops and the symbol tick is taken directly from a tick-enable input. There is no real clock switch; the block stays in one clock domain.

Software reaches the block through a byte-wide register port. It can set the enable and the source select, and it can write two self-clearing strobes: one realigns symbol timing, the other copies the counter into a beacon timestamp register. There are three 32-bit compare values. Each unit has its own enable and can match either on an absolute counter value or at an offset from the captured timestamp. A match sets a sticky interrupt flag, and software clears it by writing 1 to that flag bit.

Top module: `symcnt_core`

## Requirements
- R1: After reset, every register reads 0, `cmp_irq` is 0 and `slot_pulse` is 0.
- R2: With CTRL bit0 (enable) = 1 and CTRL bit1 (slow select) = 0, the prescaler counts every clock. The symbol counter increments at each clock edge where the prescaler holds 255, so the period is 256 clocks.
- R3: The slot counter advances on every symbol tick and wraps after 20 ticks. `slot_pulse` is high for exactly one cycle after the edge at which the slot counter wraps from 19 to 0.
- R4: Writing CTRL with bit2 = 1 while the slow source is not selected clears the prescaler and the slot counter at that edge, and no slot pulse is produced at that edge. Bit2 always reads back 0.
- R5: Writing CTRL with bit3 = 1 copies the current counter value into the timestamp register (read-only, addresses 0x08..0x0B). Bit3 always reads back 0.
- R6: While enable = 0, the counter, prescaler and slot counter hold their values, no match flag is set, and writes to the counter addresses 0x04..0x07 are ignored.
- R7: With enable = 1 and slow select = 1, the counter advances once per cycle in which `tick_slow` is high, and the CTRL bit2 resync has no effect.
- R8: When CFG bit u (u = 0..2) is set and CFG bit 4+u is clear, unit u sets flag u at the edge where a symbol tick moves the counter to the compare value. A tick on an edge that also writes the counter does not count as a match.
- R9: When CFG bit 4+u is set, unit u matches at the counter value equal to timestamp + compare value, taken modulo 2^32.
- R10: The flags (FLAG register at 0x02, bits 2:0) drive `cmp_irq`. A flag stays set until a 1 is written to its bit, and a set in the same cycle wins over a clear. A unit whose CFG enable bit is clear never sets its flag.
- R11: Register map: CTRL at 0x00, CFG at 0x01, FLAG at 0x02, counter at 0x04..0x07, timestamp at 0x08..0x0B, and compare unit u at 0x10+4u..0x13+4u. Each multi-byte value is stored with its least significant byte at the lowest address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | One-cycle symbol tick from the slow source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| cmp_irq | output | 3 | Sticky compare-match flags |
| slot_pulse | output | 1 | One-cycle pulse at each backoff-slot boundary |

## Verification
A prescaler or slot counter that drifts moves `slot_pulse` off its expected cycle at the next slot boundary, which is at most 5120 clocks later. The reference model flags this on the exact cycle. A wrong target sum or a wrong counter state shows up as a flag that sets one symbol early or late, or never sets at all, and `cmp_irq` is compared on every clock. A strobe bit that fails to self-clear, or a counter write that gets through while disabled, shows up at the next register read.

// File: rtl/symcnt_pkg.sv
package symcnt_pkg;

    localparam int CNT_W  = 32;
    localparam int BYTES  = CNT_W / 8;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CTRL = 6'h00;
    localparam logic [ADDR_W-1:0] A_CFG  = 6'h01;
    localparam logic [ADDR_W-1:0] A_FLAG = 6'h02;
    localparam logic [ADDR_W-1:0] A_CNT  = 6'h04;
    localparam logic [ADDR_W-1:0] A_TS   = 6'h08;
    localparam logic [ADDR_W-1:0] A_CMP  = 6'h10;

    typedef struct packed {
        logic mts;
        logic resync;
        logic slow;
        logic en;
    } ctrl_wr_t;

    typedef struct packed {
        logic rel;
        logic en;
    } cmp_cfg_t;

    function automatic logic [CNT_W-1:0] put_byte(logic [CNT_W-1:0] w,
                                                  logic [1:0] idx,
                                                  logic [7:0] b);
        logic [CNT_W-1:0] r;
        r = w;
        r[int'(idx)*8 +: 8] = b;
        return r;
    endfunction

    function automatic logic [7:0] get_byte(logic [CNT_W-1:0] w, logic [1:0] idx);
        return w[int'(idx)*8 +: 8];
    endfunction

endpackage

// File: rtl/symcnt_timebase.sv
module symcnt_timebase #(
    parameter int PRESC_W  = 8,
    parameter int SLOT_LEN = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic slow,
    input  logic tick_slow,
    input  logic resync,
    output logic sym_tick,
    output logic slot_pulse
);
    localparam int SLOT_W = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_LEN - 1);

    logic [PRESC_W-1:0] presc;
    logic [SLOT_W-1:0]  slot;
    logic               do_sync;

    assign do_sync  = resync & ~slow;
    assign sym_tick = slow ? (en & tick_slow) : (en & (presc == '1));

    always_ff @(posedge clk) begin
        if (rst) begin
            presc      <= '0;
            slot       <= '0;
            slot_pulse <= 1'b0;
        end else begin
            slot_pulse <= 1'b0;
            if (do_sync)
                presc <= '0;
            else if (en & ~slow)
                presc <= presc + 1'b1;
            if (do_sync) begin
                slot <= '0;
            end else if (sym_tick) begin
                if (slot == SLOT_LAST) begin
                    slot       <= '0;
                    slot_pulse <= 1'b1;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    p_slot_range_r3: assert property (@(posedge clk) disable iff (rst)
        32'(slot) < SLOT_LEN);
    p_slot_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        slot_pulse |-> (slot == '0));
    p_resync_clear_r4: assert property (@(posedge clk) disable iff (rst)
        do_sync |=> (presc == '0) && (slot == '0) && !slot_pulse);

endmodule

// File: rtl/symcnt_cmp_unit.sv
module symcnt_cmp_unit
    import symcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmp_cfg_t         cfg,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic [CNT_W-1:0] ts,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             step,
    input  logic             clr,
    output logic             flag
);
    logic [CNT_W-1:0] target;
    logic             hit;

    assign target = cfg.rel ? (ts + cmp_val) : cmp_val;
    assign hit    = step & cfg.en & (cnt_next == target);

    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= (flag & ~clr) | hit;
    end

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    p_flag_cause_r8: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(step && cfg.en)) |=> !flag);

endmodule

// File: rtl/symcnt_core.sv
module symcnt_core
    import symcnt_pkg::*;
#(
    parameter int N_CMP    = 3,
    parameter int PRESC_W  = 8,
    parameter int SLOT_LEN = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_slow,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [N_CMP-1:0]  cmp_irq,
    output logic              slot_pulse
);
    ctrl_wr_t         ctrl_w;
    logic             en_q, slow_q;
    logic [N_CMP-1:0] cfg_en_q, cfg_rel_q;
    logic [CNT_W-1:0] cnt_q, ts_q, cnt_inc;
    logic [CNT_W-1:0] cmp_q [N_CMP];
    logic             wr_ctrl, wr_cfg, cnt_wr, sym_tick;
    logic [N_CMP-1:0] flag_clr;

    assign ctrl_w   = ctrl_wr_t'(reg_wdata[3:0]);
    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_cfg   = reg_wr && (reg_addr == A_CFG);
    assign cnt_wr   = reg_wr && en_q && (reg_addr[5:2] == A_CNT[5:2]);
    assign flag_clr = (reg_wr && (reg_addr == A_FLAG)) ? reg_wdata[N_CMP-1:0] : '0;
    assign cnt_inc  = cnt_q + 1'b1;

    symcnt_timebase #(.PRESC_W(PRESC_W), .SLOT_LEN(SLOT_LEN)) u_tb (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .slow      (slow_q),
        .tick_slow (tick_slow),
        .resync    (wr_ctrl & ctrl_w.resync),
        .sym_tick  (sym_tick),
        .slot_pulse(slot_pulse)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b0;
            slow_q    <= 1'b0;
            cfg_en_q  <= '0;
            cfg_rel_q <= '0;
            cnt_q     <= '0;
            ts_q      <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q   <= ctrl_w.en;
                slow_q <= ctrl_w.slow;
            end
            if (wr_cfg) begin
                cfg_en_q  <= reg_wdata[N_CMP-1:0];
                cfg_rel_q <= reg_wdata[4 +: N_CMP];
            end
            if (cnt_wr)
                cnt_q <= put_byte(cnt_q, reg_addr[1:0], reg_wdata);
            else if (sym_tick)
                cnt_q <= cnt_inc;
            if (wr_ctrl && ctrl_w.mts)
                ts_q <= cnt_q;
        end
    end

    for (genvar u = 0; u < N_CMP; u++) begin : g_cmp
        localparam logic [3:0] UNIT_SLOT = A_CMP[5:2] + 4'(u);
        logic     sel;
        cmp_cfg_t cfg;

        assign sel = reg_wr && (reg_addr[5:2] == UNIT_SLOT);
        assign cfg = '{rel: cfg_rel_q[u], en: cfg_en_q[u]};

        always_ff @(posedge clk) begin
            if (rst)      cmp_q[u] <= '0;
            else if (sel) cmp_q[u] <= put_byte(cmp_q[u], reg_addr[1:0], reg_wdata);
        end

        symcnt_cmp_unit u_unit (
            .clk     (clk),
            .rst     (rst),
            .cfg     (cfg),
            .cmp_val (cmp_q[u]),
            .ts      (ts_q),
            .cnt_next(cnt_inc),
            .step    (sym_tick & ~cnt_wr),
            .clr     (flag_clr[u]),
            .flag    (cmp_irq[u])
        );
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == A_CTRL) begin
            reg_rdata = {6'b0, slow_q, en_q};
        end else if (reg_addr == A_CFG) begin
            reg_rdata[N_CMP-1:0]  = cfg_en_q;
            reg_rdata[4 +: N_CMP] = cfg_rel_q;
        end else if (reg_addr == A_FLAG) begin
            reg_rdata[N_CMP-1:0] = cmp_irq;
        end else if (reg_addr[5:2] == A_CNT[5:2]) begin
            reg_rdata = get_byte(cnt_q, reg_addr[1:0]);
        end else if (reg_addr[5:2] == A_TS[5:2]) begin
            reg_rdata = get_byte(ts_q, reg_addr[1:0]);
        end else begin
            for (int u = 0; u < N_CMP; u++)
                if (reg_addr[5:2] == (A_CMP[5:2] + 4'(u)))
                    reg_rdata = get_byte(cmp_q[u], reg_addr[1:0]);
        end
    end

    p_hold_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> (cnt_q == $past(cnt_q)));
    p_ts_capture_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl && ctrl_w.mts) |=> (ts_q == $past(cnt_q)));
    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        (sym_tick && !cnt_wr) |=> (cnt_q == $past(cnt_q) + 32'd1));
    p_slow_tick_r7: assert property (@(posedge clk) disable iff (rst)
        (slow_q && !tick_slow && !cnt_wr) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: tb/sim_symcnt_core.sv
module sim_symcnt_core;
    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_slow = 1'b0;
    logic       reg_wr = 1'b0;
    logic [5:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] cmp_irq;
    logic       slot_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int pulses_seen = 0;
    int pulses_model = 0;
    bit finished = 0;

    // behavioural reference state
    bit          m_en, m_slow, m_pulse;
    int          m_presc, m_slot;
    logic [31:0] m_cnt, m_ts;
    logic [31:0] m_cmp [3];
    bit          m_cen [3];
    bit          m_rel [3];
    bit          m_flag [3];

    symcnt_core u0 (
        .clk(clk), .rst(rst), .tick_slow(tick_slow), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmp_irq(cmp_irq), .slot_pulse(slot_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_slow = 0; m_pulse = 0; m_presc = 0; m_slot = 0;
            m_cnt = 0; m_ts = 0;
            for (int u = 0; u < 3; u++) begin
                m_cmp[u] = 0; m_cen[u] = 0; m_rel[u] = 0; m_flag[u] = 0;
            end
        end else begin
            bit tick, sync, cwr;
            logic [31:0] nxt, old_cnt;
            int bi;
            tick = m_slow ? (m_en && tick_slow) : (m_en && m_presc == 255);
            sync = reg_wr && reg_addr == 6'h00 && reg_wdata[2] && !m_slow;
            cwr  = reg_wr && m_en && reg_addr >= 6'h04 && reg_addr <= 6'h07;
            old_cnt = m_cnt;
            nxt = m_cnt + 1;
            m_pulse = 0;
            for (int u = 0; u < 3; u++) begin
                logic [31:0] tgt;
                bit clr;
                tgt = m_rel[u] ? m_ts + m_cmp[u] : m_cmp[u];
                clr = reg_wr && reg_addr == 6'h02 && reg_wdata[u];
                if (clr) m_flag[u] = 0;
                if (tick && !cwr && m_cen[u] && nxt == tgt) m_flag[u] = 1;
            end
            if (sync) begin
                m_presc = 0; m_slot = 0;
            end else begin
                if (m_en && !m_slow) m_presc = (m_presc + 1) % 256;
                if (tick) begin
                    if (m_slot == 19) begin m_slot = 0; m_pulse = 1; pulses_model++; end
                    else m_slot++;
                end
            end
            if (cwr) begin
                bi = int'(reg_addr) - 4;
                m_cnt[bi*8 +: 8] = reg_wdata;
            end else if (tick) m_cnt = nxt;
            if (reg_wr && reg_addr == 6'h00 && reg_wdata[3]) m_ts = old_cnt;
            if (reg_wr && reg_addr == 6'h00) begin
                m_en = reg_wdata[0]; m_slow = reg_wdata[1];
            end
            if (reg_wr && reg_addr == 6'h01)
                for (int u = 0; u < 3; u++) begin
                    m_cen[u] = reg_wdata[u]; m_rel[u] = reg_wdata[4+u];
                end
            if (reg_wr && reg_addr >= 6'h10 && reg_addr <= 6'h1B) begin
                bi = int'(reg_addr) - 16;
                m_cmp[bi/4][(bi%4)*8 +: 8] = reg_wdata;
            end
        end
    end

    function automatic logic [7:0] model_read(logic [5:0] a);
        int i;
        i = int'(a);
        if (i == 0) return {6'b0, m_slow, m_en};
        if (i == 1) return {1'b0, m_rel[2], m_rel[1], m_rel[0], 1'b0, m_cen[2], m_cen[1], m_cen[0]};
        if (i == 2) return {5'b0, m_flag[2], m_flag[1], m_flag[0]};
        if (i >= 4 && i <= 7) return m_cnt[(i-4)*8 +: 8];
        if (i >= 8 && i <= 11) return m_ts[(i-8)*8 +: 8];
        if (i >= 16 && i <= 27) return m_cmp[(i-16)/4][((i-16)%4)*8 +: 8];
        return 8'h00;
    endfunction

    // per-clock comparison of outputs against the model (R3, R8, R9, R10)
    always @(negedge clk) begin
        if (!rst && !finished) begin
            logic [2:0] ef;
            ef = {m_flag[2], m_flag[1], m_flag[0]};
            checks++;
            if (slot_pulse) pulses_seen++;
            if (cmp_irq !== ef || slot_pulse !== m_pulse) begin
                errors++;
                $display("FAIL R3/R10 cycle %0d: irq=%b pulse=%b expected irq=%b pulse=%b",
                         cycles, cmp_irq, slot_pulse, ef, m_pulse);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wr32(input logic [5:0] base, input logic [31:0] v);
        for (int b = 0; b < 4; b++) wr(base + 6'(b), v[b*8 +: 8]);
    endtask

    task automatic rd_chk(input logic [5:0] a, input string tag);
        logic [7:0] e;
        @(negedge clk);
        reg_addr = a;
        #1;
        e = model_read(a);
        checks++;
        if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s addr 0x%02h: got 0x%02h expected 0x%02h", tag, a, reg_rdata, e);
        end
    endtask

    task automatic direct_chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic slow_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_slow = 1'b1;
            @(negedge clk); tick_slow = 1'b0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd_chk(6'h00, "R1"); rd_chk(6'h01, "R1"); rd_chk(6'h02, "R1");
        rd_chk(6'h04, "R1"); rd_chk(6'h07, "R1"); rd_chk(6'h08, "R1");
        rd_chk(6'h10, "R1");
        direct_chk(cmp_irq == 3'b000 && slot_pulse == 1'b0, "R1 outputs", int'(cmp_irq), 0);

        // R2: fast counting
        wr(6'h00, 8'h01);
        repeat (800) @(negedge clk);
        rd_chk(6'h04, "R2");
        direct_chk(m_cnt == 32'd3, "R2 model count", int'(m_cnt), 3);

        // R3: slot pulses
        repeat (20 * 256 + 300) @(negedge clk);
        direct_chk(pulses_seen == pulses_model && pulses_seen > 0, "R3 pulse count",
                   pulses_seen, pulses_model);

        // R4: resync
        repeat (1000) @(negedge clk);
        wr(6'h00, 8'h05);
        rd_chk(6'h00, "R4");
        repeat (5400) @(negedge clk);
        direct_chk(pulses_seen == pulses_model, "R4 pulse count", pulses_seen, pulses_model);

        // R8 setup, R5 timestamp
        wr32(6'h10, 32'h0000_00F3);
        wr32(6'h18, 32'h0000_00F2);
        wr(6'h01, 8'h01);
        wr32(6'h04, 32'h0000_00F0);
        wr(6'h00, 8'h09);
        rd_chk(6'h08, "R5"); rd_chk(6'h00, "R5");
        repeat (4 * 256 + 50) @(negedge clk);
        rd_chk(6'h02, "R8");
        direct_chk(cmp_irq[0] == 1'b1, "R8 flag0", int'(cmp_irq[0]), 1);
        direct_chk(cmp_irq[2] == 1'b0, "R10 disabled unit", int'(cmp_irq[2]), 0);

        // R9: relative compare with wrap
        wr32(6'h04, 32'hFFFF_FFF0);
        wr(6'h00, 8'h09);
        wr32(6'h14, 32'h0000_0014);
        wr(6'h01, 8'h23);
        repeat (20 * 256 + 300) @(negedge clk);
        rd_chk(6'h02, "R9");
        direct_chk(cmp_irq[1] == 1'b1, "R9 flag1", int'(cmp_irq[1]), 1);
        rd_chk(6'h07, "R9");

        // R10: write-1-clear
        wr(6'h02, 8'h03);
        rd_chk(6'h02, "R10");
        direct_chk(cmp_irq == 3'b000, "R10 cleared", int'(cmp_irq), 0);

        // R6: disabled
        wr(6'h00, 8'h00);
        wr(6'h04, 8'h55);
        rd_chk(6'h04, "R6");
        repeat (600) @(negedge clk);
        rd_chk(6'h04, "R6"); rd_chk(6'h05, "R6");

        // R7: slow source
        wr(6'h00, 8'h03);
        slow_ticks(5);
        rd_chk(6'h04, "R7");
        wr(6'h00, 8'h07);
        rd_chk(6'h00, "R7");
        slow_ticks(25);
        rd_chk(6'h04, "R7");
        direct_chk(pulses_seen == pulses_model, "R7 pulse count", pulses_seen, pulses_model);

        // R11: byte order and map
        rd_chk(6'h14, "R11"); rd_chk(6'h15, "R11"); rd_chk(6'h17, "R11");
        rd_chk(6'h0B, "R11"); rd_chk(6'h10, "R11"); rd_chk(6'h01, "R11");

        repeat (4) @(negedge clk);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule